// File: doc/BRIEF.md
# Converter Input Channel Scan Sequencer

This block lives in the digital core of a multichannel converter and decides which analog input is sampled by each conversion. It decodes four settings from a configuration word: the index of the final channel in the scan, whether inputs are taken one at a time or as adjacent pairs, whether a temperature-sensor slot is added, and whether automatic scanning is on at all. On every conversion strobe it registers a channel code and a pair flag toward the analog multiplexer control, then moves its internal position forward.

The scan always starts at input 0 and climbs to the programmed final channel, then returns to input 0 and repeats. A temperature slot can be placed after the final channel. The configuration path pulses a reload input whenever new settings are written, which forces the next conversion back to input 0. When scanning is off, each conversion takes the channel named directly in the configuration field.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is high, and after it, `chan_code` is 0 and `pair_sel` is 0. The first conversion after reset with scanning enabled presents channel 0.
- R2: Configuration fields in `cfg_word`: final channel index at bits 9:7, paired mode at bit 10, temperature slot enable at bit 11, scan enable at bit 12. The other bits are ignored.
- R3: In single mode each conversion presents the codes 0, 1, 2, ... up to the final channel, one per strobe, with `pair_sel` low.
- R4: In paired mode each conversion presents the even codes 0, 2, 4, ..., where code 2k stands for channels 2k and 2k+1. The last pair is the one holding the final channel, and `pair_sel` is high.
- R5: With the temperature slot enabled, the conversion after the last channel or pair presents code 4'b1000 with `pair_sel` low. The following conversion presents channel 0.
- R6: The scan wraps to channel 0 and repeats without end. Without a temperature slot, the conversion after the last channel or pair presents channel 0.
- R7: Outputs change only on a clock edge where `conv_start` is high. They are registered one cycle after the strobe and hold between strobes.
- R8: After a `reload` pulse, the next conversion presents channel 0. A `reload` in the same cycle as `conv_start` makes that conversion present channel 0, and the scan continues from there.
- R9: With scan enable low, each conversion presents the code equal to the final-channel field (upper bit 0), and `pair_sel` equals the paired-mode bit. The scan position is cleared, so the first conversion after scanning is re-enabled presents channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 14 | Configuration word holding the scan fields |
| conv_start | input | 1 | One-cycle conversion strobe |
| reload | input | 1 | Pulse on any configuration write; restarts the scan |
| chan_code | output | 4 | Channel code for the current conversion; 4'b1000 selects the temperature sensor |
| pair_sel | output | 1 | High when the code names a channel pair |

## Verification
The restart request and the conversion strobe can arrive in the same cycle. In that case the restart must win for the current conversion and still let the scan advance. The bench moves the scan into its middle and then raises `reload` and `conv_start` together. It expects channel 0 on that conversion and the next step (1, or 2 in paired mode) on the one after. Every combination of final channel, pairing and temperature slot is swept over more than two full scan periods, and the expected codes are computed from the slot number modulo the scan length.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;

    parameter int IDX_W     = 3;
    parameter int CFG_W     = 14;
    parameter int LAST_LSB  = 7;
    parameter int PAIR_BIT  = 10;
    parameter int TEMP_BIT  = 11;
    parameter int EN_BIT    = 12;

    localparam int CODE_W = IDX_W + 1;
    localparam logic [CODE_W-1:0] TEMP_CODE = CODE_W'(1) << IDX_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        idx_t last;
        logic paired;
        logic temp_en;
        logic enable;
    } scan_cfg_t;

    typedef struct packed {
        code_t code;
        logic  pair;
    } slot_t;

    function automatic scan_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        scan_cfg_t c;
        c.last    = w[LAST_LSB +: IDX_W];
        c.paired  = w[PAIR_BIT];
        c.temp_en = w[TEMP_BIT];
        c.enable  = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [IDX_W:0] step_from(input idx_t idx, input logic paired);
        return {1'b0, idx} + {{(IDX_W-1){1'b0}}, paired, ~paired};
    endfunction

    function automatic slot_t chan_slot(input idx_t idx, input logic paired);
        slot_t s;
        s.code = {1'b0, idx};
        s.pair = paired;
        return s;
    endfunction

endpackage

// File: rtl/chan_scan_cfg_dec.sv
module chan_scan_cfg_dec
    import chan_scan_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output scan_cfg_t        cfg
);
    logic unused_cfg_bits;

    always_comb begin
        cfg = decode_cfg(cfg_word);
    end

    assign unused_cfg_bits = ^{cfg_word[LAST_LSB-1:0], cfg_word[CFG_W-1]};

endmodule

// File: rtl/chan_scan_state.sv
module chan_scan_state
    import chan_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  scan_cfg_t cfg,
    input  logic      conv_start,
    input  logic      reload,
    output slot_t     cur_slot
);
    idx_t           idx_q;
    logic           temp_pend_q;
    idx_t           eff_idx;
    logic           eff_pend;
    logic [IDX_W:0] nxt;
    logic           past_last;

    always_comb begin
        eff_idx   = reload ? '0 : idx_q;
        eff_pend  = reload ? 1'b0 : temp_pend_q;
        nxt       = step_from(eff_idx, cfg.paired);
        past_last = nxt > {1'b0, cfg.last};
        if (eff_pend) begin
            cur_slot.code = TEMP_CODE;
            cur_slot.pair = 1'b0;
        end else begin
            cur_slot = chan_slot(eff_idx, cfg.paired);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.enable) begin
            idx_q       <= '0;
            temp_pend_q <= 1'b0;
        end else if (conv_start) begin
            if (eff_pend) begin
                idx_q       <= '0;
                temp_pend_q <= 1'b0;
            end else if (past_last) begin
                idx_q       <= '0;
                temp_pend_q <= cfg.temp_en;
            end else begin
                idx_q       <= nxt[IDX_W-1:0];
                temp_pend_q <= 1'b0;
            end
        end else if (reload) begin
            idx_q       <= '0;
            temp_pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_scan_out.sv
module chan_scan_out
    import chan_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      conv_start,
    input  scan_cfg_t cfg,
    input  slot_t     cur_slot,
    output slot_t     out_slot
);
    slot_t pick;

    always_comb begin
        if (cfg.enable) pick = cur_slot;
        else            pick = chan_slot(cfg.last, cfg.paired);
    end

    always_ff @(posedge clk) begin
        if (rst)             out_slot <= '0;
        else if (conv_start) out_slot <= pick;
    end

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
    import chan_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              conv_start,
    input  logic              reload,
    output logic [CODE_W-1:0] chan_code,
    output logic              pair_sel
);
    scan_cfg_t cfg;
    slot_t     cur_slot;
    slot_t     out_slot;

    chan_scan_cfg_dec dec_i (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    chan_scan_state st_i (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .conv_start (conv_start),
        .reload     (reload),
        .cur_slot   (cur_slot)
    );

    chan_scan_out out_i (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .cfg        (cfg),
        .cur_slot   (cur_slot),
        .out_slot   (out_slot)
    );

    assign chan_code = out_slot.code;
    assign pair_sel  = out_slot.pair;

endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk
    import chan_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              conv_start,
    input logic              reload,
    input logic [CODE_W-1:0] chan_code,
    input logic              pair_sel
);
    logic en;
    logic unused_chk_bits;
    assign en = cfg_word[EN_BIT];
    assign unused_chk_bits = ^{cfg_word[LAST_LSB-1:0], cfg_word[CFG_W-1:EN_BIT+1],
                               cfg_word[TEMP_BIT]};

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !conv_start |=> ($stable(chan_code) && $stable(pair_sel)));

    p_temp_unpaired_r5: assert property (@(posedge clk) disable iff (rst)
        (chan_code == TEMP_CODE) |-> !pair_sel);

    p_after_temp_r5: assert property (@(posedge clk) disable iff (rst)
        (conv_start && en && (chan_code == TEMP_CODE)) |=> (chan_code == '0));

    p_reload_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (conv_start && reload && en) |=> (chan_code == '0));

    p_direct_r9: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !en) |=>
            (chan_code == {1'b0, $past(cfg_word[LAST_LSB +: IDX_W])}) &&
            (pair_sel == $past(cfg_word[PAIR_BIT])));

endmodule

bind chan_scan_seq chan_scan_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_word   (cfg_word),
    .conv_start (conv_start),
    .reload     (reload),
    .chan_code  (chan_code),
    .pair_sel   (pair_sel)
);

// File: tb/chan_scan_seq_tb.sv
module chan_scan_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cfg_word = '0;
    logic        conv_start = 1'b0;
    logic        reload = 1'b0;
    logic [3:0]  chan_code;
    logic        pair_sel;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    chan_scan_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_word   (cfg_word),
        .conv_start (conv_start),
        .reload     (reload),
        .chan_code  (chan_code),
        .pair_sel   (pair_sel)
    );

    function automatic logic [13:0] mk_cfg(int last, bit pr, bit tmp, bit en, logic [6:0] junk);
        logic [13:0] w;
        w        = '0;
        w[6:0]   = junk;
        w[9:7]   = last[2:0];
        w[10]    = pr;
        w[11]    = tmp;
        w[12]    = en;
        w[13]    = junk[0];
        return w;
    endfunction

    function automatic int n_chan(int last, bit pr);
        return pr ? (last / 2 + 1) : (last + 1);
    endfunction

    function automatic logic [3:0] exp_code(int k, int last, bit pr, bit tmp);
        int m;
        m = k % (n_chan(last, pr) + (tmp ? 1 : 0));
        if (m < n_chan(last, pr)) return pr ? 4'(2 * m) : 4'(m);
        return 4'b1000;
    endfunction

    function automatic logic exp_pair(int k, int last, bit pr, bit tmp);
        int m;
        m = k % (n_chan(last, pr) + (tmp ? 1 : 0));
        return pr && (m < n_chan(last, pr));
    endfunction

    task automatic chk(string req, logic [3:0] ec, logic ep);
        n_checks++;
        if (chan_code !== ec || pair_sel !== ep) begin
            n_err++;
            $display("FAIL %s: code=%b pair=%b expected code=%b pair=%b",
                     req, chan_code, pair_sel, ec, ep);
        end
    endtask

    task automatic conv(bit with_reload);
        @(negedge clk);
        conv_start = 1'b1;
        reload     = with_reload;
        @(negedge clk);
        conv_start = 1'b0;
        reload     = 1'b0;
    endtask

    task automatic pulse_reload();
        @(negedge clk);
        reload = 1'b1;
        @(negedge clk);
        reload = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        cfg_word = mk_cfg(5, 1'b1, 1'b1, 1'b1, 7'h55);
        repeat (3) @(negedge clk);
        chk("R1 reset held", 4'd0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 4'd0, 1'b0);
        cfg_word = mk_cfg(3, 1'b0, 1'b0, 1'b1, 7'h00);
        conv(1'b0);
        chk("R1 first conversion", 4'd0, 1'b0);

        // R2 R3 R4 R5 R6: sweep every field combination, junk in unused bits
        for (int last = 0; last < 8; last++) begin
            for (int pr = 0; pr < 2; pr++) begin
                for (int tmp = 0; tmp < 2; tmp++) begin
                    int per;
                    per = n_chan(last, pr[0]) + tmp;
                    cfg_word = mk_cfg(last, pr[0], tmp[0], 1'b1, 7'(last * 13 + pr * 5 + tmp));
                    pulse_reload();
                    for (int k = 0; k < 2 * per + 1; k++) begin
                        conv(1'b0);
                        chk(tmp ? "R5 temp slot scan" : (pr ? "R4 paired scan" : "R3 R6 single scan"),
                            exp_code(k, last, pr[0], tmp[0]), exp_pair(k, last, pr[0], tmp[0]));
                    end
                end
            end
        end

        // R7: no strobe, outputs hold
        cfg_word = mk_cfg(7, 1'b0, 1'b0, 1'b1, 7'h00);
        pulse_reload();
        conv(1'b0);
        conv(1'b0);
        repeat (4) @(negedge clk);
        chk("R7 hold without strobe", 4'd1, 1'b0);

        // R8: reload alone, then coincident reload and strobe
        conv(1'b0);
        pulse_reload();
        chk("R8 reload alone keeps outputs", 4'd2, 1'b0);
        conv(1'b0);
        chk("R8 after reload", 4'd0, 1'b0);
        conv(1'b0);
        conv(1'b0);
        conv(1'b1);
        chk("R8 coincident reload", 4'd0, 1'b0);
        conv(1'b0);
        chk("R8 continues after coincident", 4'd1, 1'b0);
        cfg_word = mk_cfg(7, 1'b1, 1'b1, 1'b1, 7'h00);
        pulse_reload();
        conv(1'b0);
        conv(1'b0);
        conv(1'b1);
        chk("R8 coincident paired", 4'd0, 1'b1);
        conv(1'b0);
        chk("R8 paired continues", 4'd2, 1'b1);

        // R9: scanning off, direct selection, then restart at zero
        cfg_word = mk_cfg(6, 1'b0, 1'b1, 1'b0, 7'h00);
        conv(1'b0);
        chk("R9 direct select", 4'd6, 1'b0);
        cfg_word = mk_cfg(3, 1'b1, 1'b0, 1'b0, 7'h00);
        conv(1'b0);
        chk("R9 direct paired flag", 4'd3, 1'b1);
        cfg_word = mk_cfg(7, 1'b0, 1'b0, 1'b1, 7'h00);
        conv(1'b0);
        chk("R9 re-enable starts at zero", 4'd0, 1'b0);
        conv(1'b0);
        chk("R9 re-enable advances", 4'd1, 1'b0);

        // R1: reset in mid-scan
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-scan reset", 4'd0, 1'b0);
        rst = 1'b0;
        conv(1'b0);
        chk("R1 scan restarts", 4'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule